// File: doc/BRIEF.md
# SerDes Indirect Register Access Engine

This engine carries out a single read or write of one SerDes control register. The SerDes registers cannot be addressed directly. Each one is reached through a paged window inside a memory-mapped PHY. A page-select word written to the PHY picks the window, and a word-aligned access inside that window then reaches the register. The SerDes itself is driven through three registers: a control register that holds a busy flag and a start command, an address register and a data register. Every operation polls busy before it starts. A read also polls busy again after its start command.

A client hands over one request: a PHY index, a read/write flag, a 16-bit SerDes register address and the write data. The engine emits the whole sequence of single-beat transfers on a simple valid/ready master port. It ends with a one-cycle done pulse that carries the read data and an error flag. The engine waits a fixed number of idle cycles between busy reads. It gives up with an error after a set number of busy replies, so a stuck PHY cannot hang it.

Top module: `sdes_indirect_eng`

## Requirements
- R1: Before each window access, the engine writes a page-select word to the PHY base plus 0x800. The word holds the device code in bits 11:7 and the SerDes register address bits 15:9 in bits 6:0. All other bits are zero.
- R2: PHY n has its base at BASE_ADDR + n*PHY_STRIDE. The window access goes to that base ORed with the SerDes register address bits 8:0 shifted left by two. The control, address and data registers sit at 0x80A0, 0x80A1 and 0x80A2.
- R3: The device code is 31 when the PHY index is 5 and 5 for every other index.
- R4: A read runs these steps in order: poll control until idle; write the target address to the address register; write 1 to control; poll control until idle; read the data register.
- R5: A write runs these steps in order: poll control until idle; write the target address to the address register; write the data to the data register; write 3 to control (bit 0 start, bit 1 write). It does not poll after the start.
- R6: Bit 0 of a control read means busy. While it is set, the poll repeats, and the engine does not move to the next step until a read returns it clear.
- R7: Exactly POLL_GAP cycles with m_valid low separate a busy control read from the next poll's page-select transfer. Every other transfer is presented in the cycle right after the previous handshake.
- R8: Suppose the POLL_LIMIT-th consecutive control read of one poll still reports busy. The engine then stops the request and pulses done with err=1 and rdata=0.
- R9: req_ready is 1 only while idle. It falls in the cycle after acceptance and rises with the done pulse, and req_valid has no effect in between.
- R10: done is high for one cycle, in the cycle after the last transfer's handshake. A successful read returns the data register value in rdata. A write returns rdata=0. err is 0 on success.
- R11: While m_valid is high and m_ready is low, m_valid, m_write, m_addr and m_wdata hold their values.
- R12: During and after reset, req_ready=1, m_valid=0 and done=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Engine idle, request taken when valid |
| req_phy | input | PHY_IDX_W | PHY index |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | SerDes register address |
| req_wdata | input | DATA_W | Write data |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | DATA_W | Read result, valid with done |
| err | output | 1 | Poll limit reached, valid with done |
| m_valid | output | 1 | Master transfer request |
| m_ready | input | 1 | Transfer accepted |
| m_write | output | 1 | Transfer direction, 1 = write |
| m_addr | output | ADDR_W | Transfer byte address |
| m_wdata | output | DATA_W | Transfer write data |
| m_rdata | input | DATA_W | Read data, sampled on the handshake |

## Verification
The first page-select transfer is due one cycle after a request is accepted. Each later transfer is due one cycle after the previous handshake. The exception is a busy reply, after which POLL_GAP idle cycles come first. done is due exactly one cycle after the final handshake. The bench builds the full expected transfer list, including idle-gap counts, when a request is accepted. On each falling edge it compares the master port, req_ready and done against that list, so any early, late, missing or extra transfer shows up in the cycle where it happens. The bench varies busy counts and ready stalls to move these due cycles, and checks each case.

// File: rtl/sdes_ind_pkg.sv
package sdes_ind_pkg;
   typedef enum logic [3:0] {
      ST_IDLE, ST_POLL_A, ST_GAP_A, ST_SET_ADDR, ST_SET_DATA,
      ST_KICK, ST_POLL_B, ST_GAP_B, ST_GET_DATA
   } step_e;

   localparam logic [15:0] SREG_CTL  = 16'h80A0;
   localparam logic [15:0] SREG_ADR  = 16'h80A1;
   localparam logic [15:0] SREG_DAT  = 16'h80A2;
   localparam logic [11:0] PAGE_OFS  = 12'h800;
   localparam int          CTL_BUSY  = 0;
   localparam int          CTL_WRSEL = 1;
endpackage

// File: rtl/sdes_ind_addr.sv
module sdes_ind_addr #(
   parameter int                ADDR_W      = 32,
   parameter int                DATA_W      = 32,
   parameter int                PHY_IDX_W   = 3,
   parameter logic [ADDR_W-1:0] BASE_ADDR   = 32'hFFF5_8000,
   parameter logic [ADDR_W-1:0] PHY_STRIDE  = 32'h0000_1000,
   parameter int                SPECIAL_PHY = 5,
   parameter logic [4:0]        DEV_STD     = 5'd5,
   parameter logic [4:0]        DEV_SPECIAL = 5'd31
) (
   input  logic [PHY_IDX_W-1:0] phy_idx,
   input  logic [15:0]          reg_addr,
   output logic [ADDR_W-1:0]    page_addr,
   output logic [DATA_W-1:0]    page_word,
   output logic [ADDR_W-1:0]    data_addr
);
   import sdes_ind_pkg::*;
   localparam int PAD_W = DATA_W - 12;
   localparam int OFS_W = ADDR_W - 11;

   logic [ADDR_W-1:0] phy_base;
   logic [4:0]        dev;

   assign phy_base  = BASE_ADDR + (ADDR_W'(phy_idx) * PHY_STRIDE);
   assign dev       = (phy_idx == PHY_IDX_W'(SPECIAL_PHY)) ? DEV_SPECIAL : DEV_STD;
   assign page_addr = phy_base + ADDR_W'(PAGE_OFS);
   assign page_word = {{PAD_W{1'b0}}, dev, reg_addr[15:9]};
   assign data_addr = phy_base | {{OFS_W{1'b0}}, reg_addr[8:0], 2'b00};
endmodule

// File: rtl/sdes_ind_gap.sv
module sdes_ind_gap #(
   parameter int POLL_GAP = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   output logic zero
);
   localparam int GAP_W = $clog2(POLL_GAP + 1);
   logic [GAP_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)             cnt <= '0;
      else if (load)          cnt <= GAP_W'(POLL_GAP - 1);
      else if (cnt != '0)     cnt <= cnt - 1'b1;
   end
   assign zero = (cnt == '0);
endmodule

// File: rtl/sdes_ind_seq.sv
module sdes_ind_seq
   import sdes_ind_pkg::*;
#(
   parameter int POLL_LIMIT = 6
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  req_valid,
   input  logic  wr,
   input  logic  m_ready,
   input  logic  busy,
   input  logic  gap_zero,
   output step_e step,
   output logic  ph,
   output logic  bus_valid,
   output logic  accept,
   output logic  fin_ok,
   output logic  fin_err,
   output logic  gap_load
);
   localparam int CNT_W = $clog2(POLL_LIMIT + 1);
   logic [CNT_W-1:0] cnt;
   logic xfer, acc_done, is_poll, last_try;

   assign bus_valid = !(step inside {ST_IDLE, ST_GAP_A, ST_GAP_B});
   assign accept    = (step == ST_IDLE) && req_valid;
   assign xfer      = bus_valid && m_ready;
   assign acc_done  = xfer && !ph;
   assign is_poll   = (step == ST_POLL_A) || (step == ST_POLL_B);
   assign last_try  = (cnt == CNT_W'(POLL_LIMIT - 1));
   assign gap_load  = acc_done && is_poll && busy && !last_try;
   assign fin_err   = acc_done && is_poll && busy && last_try;
   assign fin_ok    = acc_done && (((step == ST_KICK) && wr) || (step == ST_GET_DATA));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         step <= ST_IDLE;
         ph   <= 1'b1;
         cnt  <= '0;
      end else begin
         case (step)
            ST_IDLE: if (req_valid) begin
               step <= ST_POLL_A;
               ph   <= 1'b1;
               cnt  <= '0;
            end
            ST_GAP_A: if (gap_zero) step <= ST_POLL_A;
            ST_GAP_B: if (gap_zero) step <= ST_POLL_B;
            default: if (xfer) begin
               if (ph) ph <= 1'b0;
               else begin
                  ph <= 1'b1;
                  case (step)
                     ST_POLL_A, ST_POLL_B: begin
                        if (!busy) begin
                           cnt  <= '0;
                           step <= (step == ST_POLL_A) ? ST_SET_ADDR : ST_GET_DATA;
                        end else if (last_try) begin
                           step <= ST_IDLE;
                        end else begin
                           cnt  <= cnt + 1'b1;
                           step <= (step == ST_POLL_A) ? ST_GAP_A : ST_GAP_B;
                        end
                     end
                     ST_SET_ADDR: step <= wr ? ST_SET_DATA : ST_KICK;
                     ST_SET_DATA: step <= ST_KICK;
                     ST_KICK:     step <= wr ? ST_IDLE : ST_POLL_B;
                     default:     step <= ST_IDLE;
                  endcase
               end
            end
         endcase
      end
   end
endmodule

// File: rtl/sdes_indirect_eng.sv
module sdes_indirect_eng
   import sdes_ind_pkg::*;
#(
   parameter int                ADDR_W      = 32,
   parameter int                DATA_W      = 32,
   parameter int                PHY_IDX_W   = 3,
   parameter logic [ADDR_W-1:0] BASE_ADDR   = 32'hFFF5_8000,
   parameter logic [ADDR_W-1:0] PHY_STRIDE  = 32'h0000_1000,
   parameter int                POLL_GAP    = 3,
   parameter int                POLL_LIMIT  = 6
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   output logic                 req_ready,
   input  logic [PHY_IDX_W-1:0] req_phy,
   input  logic                 req_write,
   input  logic [15:0]          req_addr,
   input  logic [DATA_W-1:0]    req_wdata,
   output logic                 done,
   output logic [DATA_W-1:0]    rdata,
   output logic                 err,
   output logic                 m_valid,
   input  logic                 m_ready,
   output logic                 m_write,
   output logic [ADDR_W-1:0]    m_addr,
   output logic [DATA_W-1:0]    m_wdata,
   input  logic [DATA_W-1:0]    m_rdata
);
   localparam logic [DATA_W-1:0] START_WORD = DATA_W'(1) << CTL_BUSY;
   localparam logic [DATA_W-1:0] WRSEL_WORD = DATA_W'(1) << CTL_WRSEL;

   if (DATA_W < 16)     begin : g_chk_dw  $error("DATA_W must hold a 16-bit SerDes word"); end
   if (ADDR_W < 13)     begin : g_chk_aw  $error("ADDR_W must cover the page window");     end
   if (PHY_IDX_W < 3)   begin : g_chk_pw  $error("PHY_IDX_W must reach index 5");          end
   if (POLL_GAP < 1)    begin : g_chk_gap $error("POLL_GAP must be at least 1");           end
   if (POLL_LIMIT < 1)  begin : g_chk_lim $error("POLL_LIMIT must be at least 1");         end

   step_e                 step;
   logic                  ph, bus_valid, accept, fin_ok, fin_err, gap_load, gap_zero;
   logic [PHY_IDX_W-1:0]  phy_q;
   logic [15:0]           addr_q, tgt;
   logic [DATA_W-1:0]     wdata_q, page_word;
   logic                  wr_q;
   logic [ADDR_W-1:0]     page_addr, data_addr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phy_q   <= '0;
         addr_q  <= '0;
         wdata_q <= '0;
         wr_q    <= 1'b0;
      end else if (accept) begin
         phy_q   <= req_phy;
         addr_q  <= req_addr;
         wdata_q <= req_wdata;
         wr_q    <= req_write;
      end
   end

   always_comb begin
      case (step)
         ST_SET_ADDR:              tgt = SREG_ADR;
         ST_SET_DATA, ST_GET_DATA: tgt = SREG_DAT;
         default:                  tgt = SREG_CTL;
      endcase
   end

   sdes_ind_addr #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PHY_IDX_W(PHY_IDX_W),
      .BASE_ADDR(BASE_ADDR), .PHY_STRIDE(PHY_STRIDE)
   ) u_addr (
      .phy_idx(phy_q), .reg_addr(tgt),
      .page_addr(page_addr), .page_word(page_word), .data_addr(data_addr)
   );

   sdes_ind_seq #(.POLL_LIMIT(POLL_LIMIT)) u_seq (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .wr(wr_q),
      .m_ready(m_ready), .busy(m_rdata[CTL_BUSY]), .gap_zero(gap_zero),
      .step(step), .ph(ph), .bus_valid(bus_valid), .accept(accept),
      .fin_ok(fin_ok), .fin_err(fin_err), .gap_load(gap_load)
   );

   sdes_ind_gap #(.POLL_GAP(POLL_GAP)) u_gap (
      .clk(clk), .rst_n(rst_n), .load(gap_load), .zero(gap_zero)
   );

   assign req_ready = (step == ST_IDLE);
   assign m_valid   = bus_valid;
   assign m_addr    = ph ? page_addr : data_addr;
   assign m_write   = ph || (step inside {ST_SET_ADDR, ST_SET_DATA, ST_KICK});

   always_comb begin
      if (ph) m_wdata = page_word;
      else begin
         case (step)
            ST_SET_ADDR: m_wdata = DATA_W'(addr_q);
            ST_SET_DATA: m_wdata = wdata_q;
            ST_KICK:     m_wdata = START_WORD | (wr_q ? WRSEL_WORD : '0);
            default:     m_wdata = '0;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done  <= 1'b0;
         err   <= 1'b0;
         rdata <= '0;
      end else begin
         done <= fin_ok || fin_err;
         err  <= fin_err;
         if (fin_ok || fin_err)
            rdata <= (fin_ok && step == ST_GET_DATA) ? m_rdata : '0;
      end
   end
endmodule

// File: rtl/sdes_indirect_eng_chk.sv
module sdes_indirect_eng_chk #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic              done,
   input logic              err,
   input logic              m_valid,
   input logic              m_ready,
   input logic              m_write,
   input logic [ADDR_W-1:0] m_addr,
   input logic [DATA_W-1:0] m_wdata
);
   assert_hold_on_stall_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (m_valid && !m_ready) |=> (m_valid && $stable(m_addr) && $stable(m_write) && $stable(m_wdata)));

   assert_busy_after_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_after_xfer_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(m_valid && m_ready));

   assert_err_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> done);

   assert_idle_bus_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !m_valid);
endmodule

bind sdes_indirect_eng sdes_indirect_eng_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
   .done(done), .err(err), .m_valid(m_valid), .m_ready(m_ready),
   .m_write(m_write), .m_addr(m_addr), .m_wdata(m_wdata)
);

// File: tb/sdes_indirect_eng_bench.sv
module sdes_indirect_eng_bench;
   localparam logic [31:0] BASE  = 32'hFFF5_8000;
   localparam logic [31:0] STRD  = 32'h0000_1000;
   localparam int          GAP   = 3;
   localparam int          LIM   = 6;
   localparam logic [15:0] RCTL  = 16'h80A0;
   localparam logic [15:0] RADR  = 16'h80A1;
   localparam logic [15:0] RDAT  = 16'h80A2;

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_valid = 1'b0, req_write = 1'b0;
   logic [2:0]  req_phy = '0;
   logic [15:0] req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic req_ready, done, err, m_valid, m_write;
   logic m_ready;
   logic [31:0] rdata, m_addr, m_wdata, m_rdata;

   always #4 clk = ~clk;

   sdes_indirect_eng #(.BASE_ADDR(BASE), .PHY_STRIDE(STRD), .POLL_GAP(GAP), .POLL_LIMIT(LIM))
   u_sdes_indirect_eng (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_phy(req_phy), .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .done(done), .rdata(rdata), .err(err), .m_valid(m_valid), .m_ready(m_ready),
      .m_write(m_write), .m_addr(m_addr), .m_wdata(m_wdata), .m_rdata(m_rdata)
   );

   int checks = 0, failures = 0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [31:0] rdval(input logic [2:0] p, input logic [15:0] a);
      return {a ^ 16'h5AA5, 13'h0, p};
   endfunction

   // ---------------- PHY responder ----------------
   int pre_cfg = 0, post_cfg = 0;
   bit stall_en = 0;
   int busy_left, cyc;
   logic [31:0] page_q [0:7];
   logic [31:0] addr_reg, data_reg;
   logic [2:0]  rp;
   logic [15:0] rr;

   assign rp = 3'((m_addr - BASE) >> 12);
   assign rr = {page_q[rp][6:0], m_addr[10:2]};

   always_comb begin
      case (rr)
         RCTL:    m_rdata = {31'b0, busy_left != 0};
         RADR:    m_rdata = addr_reg;
         RDAT:    m_rdata = data_reg;
         default: m_rdata = '0;
      endcase
   end

   always @(posedge clk) begin
      if (!rst_n) begin
         busy_left <= 0;
         cyc       <= 0;
         m_ready   <= 1'b1;
         addr_reg  <= '0;
         data_reg  <= '0;
         for (int i = 0; i < 8; i++) page_q[i] <= '0;
      end else begin
         cyc     <= cyc + 1;
         m_ready <= stall_en ? ((cyc % 3) != 2) : 1'b1;
         if (req_valid && req_ready) busy_left <= pre_cfg;
         if (m_valid && m_ready) begin
            if (m_write) begin
               if (m_addr[11:0] == 12'h800) page_q[rp] <= m_wdata;
               else if (rr == RADR) addr_reg <= m_wdata;
               else if (rr == RDAT) data_reg <= m_wdata;
               else if (rr == RCTL && m_wdata[0] && !m_wdata[1]) begin
                  data_reg  <= rdval(rp, addr_reg[15:0]);
                  busy_left <= post_cfg;
               end
            end else if (rr == RCTL && busy_left > 0) begin
               busy_left <= busy_left - 1;
            end
         end
      end
   end

   // ---------------- reference model ----------------
   typedef struct { bit w; logic [31:0] a; logic [31:0] d; int gap; } xfer_t;
   xfer_t expq[$];
   bit in_flight = 0, just_fin = 0, cur_w = 0, exp_err = 0;
   logic [31:0] exp_rdata = '0;
   logic [4:0]  cur_dev = '0;
   int idle_cnt = 0;
   bit prev_stall = 0;
   logic [31:0] prev_addr = '0, prev_wdata = '0;

   task automatic push(input bit w, input logic [31:0] a, input logic [31:0] d, input int g);
      xfer_t e;
      e.w = w; e.a = a; e.d = d; e.gap = g;
      expq.push_back(e);
   endtask

   task automatic build(input logic [2:0] p, input bit w, input logic [15:0] a,
                        input logic [31:0] d, input int pre, input int post);
      logic [31:0] base, pa;
      logic [4:0]  dev;
      bit ok;
      base = BASE + 32'(p) * STRD;
      pa   = base + 32'h800;
      dev  = (p == 3'd5) ? 5'd31 : 5'd5;
      cur_dev = dev; cur_w = w; exp_err = 0; exp_rdata = '0;
      expq.delete();
      ok = 1;
      for (int k = 0; ; k++) begin
         push(1, pa, {20'b0, dev, RCTL[15:9]}, (k == 0) ? 0 : GAP);
         push(0, base | {23'b0, RCTL[8:0]} << 2, '0, 0);
         if (k >= pre) break;
         if (k + 1 == LIM) begin ok = 0; break; end
      end
      if (ok) begin
         push(1, pa, {20'b0, dev, RADR[15:9]}, 0);
         push(1, base | ({23'b0, RADR[8:0]} << 2), {16'b0, a}, 0);
         if (w) begin
            push(1, pa, {20'b0, dev, RDAT[15:9]}, 0);
            push(1, base | ({23'b0, RDAT[8:0]} << 2), d, 0);
            push(1, pa, {20'b0, dev, RCTL[15:9]}, 0);
            push(1, base | ({23'b0, RCTL[8:0]} << 2), 32'd3, 0);
         end else begin
            push(1, pa, {20'b0, dev, RCTL[15:9]}, 0);
            push(1, base | ({23'b0, RCTL[8:0]} << 2), 32'd1, 0);
            for (int k = 0; ; k++) begin
               push(1, pa, {20'b0, dev, RCTL[15:9]}, (k == 0) ? 0 : GAP);
               push(0, base | ({23'b0, RCTL[8:0]} << 2), '0, 0);
               if (k >= post) break;
               if (k + 1 == LIM) begin ok = 0; break; end
            end
            if (ok) begin
               push(1, pa, {20'b0, dev, RDAT[15:9]}, 0);
               push(0, base | ({23'b0, RDAT[8:0]} << 2), '0, 0);
               exp_rdata = rdval(p, a);
            end
         end
      end
      exp_err = !ok;
   endtask

   // ---------------- monitor, every falling edge ----------------
   always @(negedge clk) begin
      if (rst_n) begin
         if (prev_stall) begin
            chk("R11 valid held", 32'(m_valid), 32'd1);
            chk("R11 addr held", m_addr, prev_addr);
            chk("R11 wdata held", m_wdata, prev_wdata);
         end
         if (in_flight) begin
            if (done) begin
               chk("R10 done timing", 32'(just_fin), 32'd1);
               chk("R6 all polls seen", 32'(expq.size()), 32'd0);
               chk("R8 err", 32'(err), 32'(exp_err));
               chk("R10 rdata", rdata, exp_rdata);
               chk("R9 ready with done", 32'(req_ready), 32'd1);
               chk("R10 bus idle at done", 32'(m_valid), 32'd0);
               in_flight = 0;
            end else begin
               chk("R9 ready low", 32'(req_ready), 32'd0);
               if (just_fin) chk("R10 done missing", 32'(done), 32'd1);
               if (m_valid && m_ready) begin
                  if (expq.size() == 0) chk("R4 extra transfer", 32'd1, 32'd0);
                  else begin
                     xfer_t e;
                     e = expq.pop_front();
                     chk(cur_w ? "R5 direction" : "R4 direction", 32'(m_write), 32'(e.w));
                     chk("R2 address", m_addr, e.a);
                     if (e.w) chk("R1 wdata", m_wdata, e.d);
                     if (e.w && e.a[11:0] == 12'h800)
                        chk("R3 device", 32'(m_wdata[11:7]), 32'(cur_dev));
                     chk("R7 idle gap", 32'(idle_cnt), 32'(e.gap));
                     idle_cnt = 0;
                     if (expq.size() == 0) just_fin = 1;
                  end
               end else if (!m_valid) idle_cnt++;
            end
         end else begin
            chk("R12 idle ready", 32'(req_ready), 32'd1);
            chk("R12 idle bus", 32'(m_valid), 32'd0);
            chk("R10 no stray done", 32'(done), 32'd0);
            if (req_valid && req_ready) begin
               build(req_phy, req_write, req_addr, req_wdata, pre_cfg, post_cfg);
               in_flight = 1; just_fin = 0; idle_cnt = 0;
            end
         end
         prev_stall = m_valid && !m_ready;
         prev_addr  = m_addr;
         prev_wdata = m_wdata;
      end
   end

   // ---------------- stimulus ----------------
   task automatic run(input logic [2:0] p, input bit w, input logic [15:0] a,
                      input logic [31:0] d, input int pre, input int post,
                      input bit stall, input int hold);
      @(posedge clk); #1;
      pre_cfg = pre; post_cfg = post; stall_en = stall;
      req_phy = p; req_write = w; req_addr = a; req_wdata = d; req_valid = 1'b1;
      @(posedge clk); #1;
      req_phy = ~p; req_write = ~w; req_addr = ~a; req_wdata = ~d;   // R9 ignored while busy
      repeat (hold) @(posedge clk);
      #1 req_valid = 1'b0;
      while (in_flight) @(posedge clk);
      repeat (2) @(posedge clk);
   endtask

   initial begin
      #150000;
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R12 reset ready", 32'(req_ready), 32'd1);
      chk("R12 reset bus", 32'(m_valid), 32'd0);
      chk("R12 reset done", 32'(done), 32'd0);
      @(posedge clk); #1 rst_n = 1'b1;
      repeat (2) @(posedge clk);
      run(3'd0, 1'b0, 16'h2001, 32'h0,        0, 0, 1'b0, 0);   // R4 plain read
      run(3'd2, 1'b1, 16'h2105, 32'h0000_1234, 2, 0, 1'b0, 2);  // R5 R6 R7 write after busy
      run(3'd5, 1'b0, 16'h4305, 32'h0,        1, 3, 1'b0, 3);   // R3 special device
      run(3'd3, 1'b0, 16'hFFFF, 32'h0,        1, 1, 1'b1, 1);   // R11 stalls
      run(3'd1, 1'b0, 16'h0000, 32'h0,        LIM, 0, 1'b0, 0); // R8 timeout first poll
      run(3'd4, 1'b0, 16'h1FF0, 32'h0,        0, 9, 1'b0, 0);   // R8 timeout second poll
      run(3'd5, 1'b1, 16'h8001, 32'hDEAD_BEEF, 1, 0, 1'b1, 2);  // R3 R5 with stalls
      run(3'd7, 1'b0, 16'h0200, 32'h0,        LIM-1, LIM-1, 1'b0, 0); // R6 limit edge, success
      run(3'd6, 1'b1, 16'h01FF, 32'h0000_00A5, 0, 0, 1'b0, 1);  // R2 offset extreme
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule